// File: doc/BRIEF.md
# Deferred-Write Data Memory with Mapped I/O Port

This block sits between a small processor core and its 16-word, 4-bit data store. A store request does not write at once: in the cycle the request is raised, the block records the target address and the accumulator value. The write itself lands at the end of the next cycle. Because the storage is busy during that cycle, a read made in that cycle cannot see memory contents. By default such a read returns the value on an external 4-bit input port, and programs can use this to sample input.

The top address (all ones) does not reach storage. Reading it returns the input port. Writing it loads a 4-bit output port register, which keeps its value until the next write to that address. A mode input enables forwarding. With forwarding on, a read of the address being written in the busy cycle returns the data being written. This lets a program read a word straight after storing it, and lets stores follow each other on consecutive cycles.

Top module: `dmem_deferred`

## Requirements
- R1: After a cycle with `rst` high, `out_port` is 0 and no write is pending, so no read is redirected in the cycle after reset.
- R2: A store raised in cycle t with address A (A not all ones) writes the captured data at the end of cycle t+1. A read of A from cycle t+2 onward returns that data until A is written again.
- R3: With `fwd_en` low, a combinational read in cycle t+1 after a store returns `in_port`, whatever address is read.
- R4: With `fwd_en` high, a read in cycle t+1 of the same address as the pending store returns the pending data. A read of any other address in that cycle returns `in_port`.
- R5: With no write pending, a read of address 0xF returns `in_port`.
- R6: A store to address 0xF loads `out_port` with the captured data at the end of cycle t+1. `out_port` changes at no other time and stores to any other address leave it unchanged.
- R7: The write data is the `acc_in` value sampled in the store cycle. A change of `acc_in` in cycle t+1 does not alter what is written.
- R8: Stores raised on consecutive cycles all commit, each one cycle after its own request.
- R9: With no write pending, a read of an address other than 0xF returns the stored memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fwd_en | input | 1 | 1 selects forwarding of pending write data; 0 selects the legacy input-port return |
| st_req | input | 1 | Store request for this cycle |
| mem_addr | input | 4 | Address for the read and for a store request |
| acc_in | input | 4 | Accumulator value, captured on a store request |
| in_port | input | 4 | External input port |
| rd_data | output | 4 | Combinational read result |
| out_port | output | 4 | Registered output port, loaded by stores to 0xF |

## Verification
Reads in the busy cycle are tried in both modes, once with the same address as the pending store and once with a different address. This separates forwarding from the input-port return and shows whether the mode input is obeyed. The accumulator is changed in the cycle after each store, which shows whether the write data is captured early or late. Runs of consecutive stores, including stores to the same address and mixed with I/O writes, separate a lost or overwritten pending write from a correct overlap. A long pseudo-random stream then compares read data and the output port against a behavioural model on every cycle.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int DEF_AW = 4;
    localparam int DEF_DW = 4;

    typedef enum logic [1:0] {
        SRC_RAM  = 2'd0,
        SRC_PORT = 2'd1,
        SRC_FWD  = 2'd2
    } rd_src_e;

    // Pick the source of a read from the pending state and address matches.
    function automatic rd_src_e pick_src(input logic pend, input logic fwd,
                                         input logic hit_pend, input logic hit_io);
        rd_src_e s;
        if (pend) begin
            s = (fwd && hit_pend) ? SRC_FWD : SRC_PORT;
        end else begin
            s = hit_io ? SRC_PORT : SRC_RAM;
        end
        return s;
    endfunction

endpackage

// File: rtl/dm_pending_reg.sv
module dm_pending_reg #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_req,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          pend_vld,
    output logic [AW-1:0] pend_addr,
    output logic [DW-1:0] pend_data
);
    // Active-low write strobe: reset drives it high (idle).
    logic wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
        end else begin
            wr_n_q <= ~st_req;
        end
    end

    always_ff @(posedge clk) begin
        if (st_req) begin
            pend_addr <= st_addr;
            pend_data <= st_data;
        end
    end

    assign pend_vld = ~wr_n_q;
endmodule

// File: rtl/dm_ram.sv
module dm_ram #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dm_outport.sv
module dm_outport #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/dm_readsel.sv
module dm_readsel
    import dmem_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          fwd_en,
    input  logic          pend_vld,
    input  logic [AW-1:0] pend_addr,
    input  logic [DW-1:0] pend_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] ram_data,
    input  logic [DW-1:0] in_port,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW-1:0] IO_ADDR = {AW{1'b1}};

    rd_src_e src;

    always_comb begin
        src = pick_src(pend_vld, fwd_en, rd_addr == pend_addr, rd_addr == IO_ADDR);
        unique case (src)
            SRC_FWD:  rd_data = pend_data;
            SRC_PORT: rd_data = in_port;
            default:  rd_data = ram_data;
        endcase
    end
endmodule

// File: rtl/dmem_deferred.sv
module dmem_deferred
    import dmem_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwd_en,
    input  logic          st_req,
    input  logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] in_port,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] out_port
);
    localparam logic [AW-1:0] IO_ADDR = {AW{1'b1}};

    logic          pend_vld;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic [DW-1:0] ram_rdata;
    logic          pend_io;

    assign pend_io = (pend_addr == IO_ADDR);

    dm_pending_reg #(.AW(AW), .DW(DW)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .st_req    (st_req),
        .st_addr   (mem_addr),
        .st_data   (acc_in),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_data (pend_data)
    );

    dm_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (pend_vld && !pend_io),
        .waddr (pend_addr),
        .wdata (pend_data),
        .raddr (mem_addr),
        .rdata (ram_rdata)
    );

    dm_outport #(.DW(DW)) u_oport (
        .clk  (clk),
        .rst  (rst),
        .load (pend_vld && pend_io),
        .din  (pend_data),
        .dout (out_port)
    );

    dm_readsel #(.AW(AW), .DW(DW)) u_rsel (
        .fwd_en    (fwd_en),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_data (pend_data),
        .rd_addr   (mem_addr),
        .ram_data  (ram_rdata),
        .in_port   (in_port),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/dmem_deferred_chk.sv
module dmem_deferred_chk #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          fwd_en,
    input logic          st_req,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] acc_in,
    input logic [DW-1:0] in_port,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] out_port
);
    localparam logic [AW-1:0] IO_ADDR = {AW{1'b1}};

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> out_port == '0);

    p_legacy_port_r3: assert property (@(posedge clk) disable iff (rst)
        (!fwd_en && $past(st_req && !rst)) |-> rd_data == in_port);

    p_fwd_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && $past(st_req && !rst) && mem_addr == $past(mem_addr))
        |-> rd_data == $past(acc_in));

    p_fwd_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && $past(st_req && !rst) && mem_addr != $past(mem_addr))
        |-> rd_data == in_port);

    p_io_read_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!(st_req && !rst)) && mem_addr == IO_ADDR) |-> rd_data == in_port);

    p_oport_load_r6: assert property (@(posedge clk) disable iff (rst)
        $past(st_req && !rst && mem_addr == IO_ADDR) |=> out_port == $past(acc_in, 2));

    p_oport_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(st_req && !rst && mem_addr == IO_ADDR) |=> $stable(out_port));
endmodule

bind dmem_deferred dmem_deferred_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fwd_en   (fwd_en),
    .st_req   (st_req),
    .mem_addr (mem_addr),
    .acc_in   (acc_in),
    .in_port  (in_port),
    .rd_data  (rd_data),
    .out_port (out_port)
);

// File: tb/test_dmem_deferred.sv
module test_dmem_deferred;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fwd_en = 1'b0;
    logic       st_req = 1'b0;
    logic [3:0] mem_addr = '0;
    logic [3:0] acc_in = '0;
    logic [3:0] in_port = '0;
    logic [3:0] rd_data;
    logic [3:0] out_port;

    int vectors = 0;
    int errors  = 0;

    // Behavioural reference state
    logic [3:0] m_mem [16];
    bit         m_known [16];
    bit         m_pend = 0;
    logic [3:0] m_paddr = '0;
    logic [3:0] m_pdata = '0;
    logic [3:0] m_oport = '0;

    always #4 clk = ~clk;

    dmem_deferred i_dmem_deferred (
        .clk(clk), .rst(rst), .fwd_en(fwd_en), .st_req(st_req),
        .mem_addr(mem_addr), .acc_in(acc_in), .in_port(in_port),
        .rd_data(rd_data), .out_port(out_port)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs, compare read data and output port, then advance model.
    task automatic step(input string tag, input bit st, input logic [3:0] a,
                        input logic [3:0] d, input logic [3:0] inp, input bit fwd);
        logic [3:0] exp_rd;
        bit         have;
        @(negedge clk);
        st_req = st; mem_addr = a; acc_in = d; in_port = inp; fwd_en = fwd;
        #1;
        have = 1;
        if (m_pend) begin
            exp_rd = (fwd && a == m_paddr) ? m_pdata : inp;
        end else if (a == 4'hF) begin
            exp_rd = inp;
        end else begin
            exp_rd = m_mem[a];
            have = m_known[a];
        end
        if (have) check({tag, " rd_data"}, rd_data, exp_rd);
        check({tag, " out_port"}, out_port, m_oport);
        @(posedge clk);
        if (m_pend) begin
            if (m_paddr == 4'hF) m_oport = m_pdata;
            else begin
                m_mem[m_paddr] = m_pdata;
                m_known[m_paddr] = 1;
            end
        end
        m_pend = st; m_paddr = a; m_pdata = d;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < 16; i++) m_known[i] = 0;
        // R1: reset state
        rst = 1'b1;
        st_req = 1'b1; mem_addr = 4'h3; acc_in = 4'h9;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; st_req = 1'b0;
        #1;
        check("R1 out_port after reset", out_port, 4'h0);
        m_pend = 0; m_oport = '0;
        step("R1 no redirect", 0, 4'hF, 4'h0, 4'h6, 1);
        // R5: I/O read with nothing pending
        step("R5 io read", 0, 4'hF, 4'h0, 4'hA, 0);
        // R2 / R3 / R7: store then legacy read, acc changes in busy cycle
        step("R2 store", 1, 4'h2, 4'h5, 4'h1, 0);
        step("R3 legacy same addr", 0, 4'h2, 4'hE, 4'hC, 0);
        step("R7 capture", 0, 4'h2, 4'h0, 4'h3, 0);
        step("R9 idle read", 0, 4'h2, 4'h0, 4'h7, 0);
        // R4: forwarding hit and miss
        step("R4 store", 1, 4'h4, 4'hB, 4'h0, 1);
        step("R4 fwd hit", 0, 4'h4, 4'h2, 4'h8, 1);
        step("R4 store2", 1, 4'h5, 4'h6, 4'h0, 1);
        step("R4 fwd miss", 0, 4'h2, 4'h1, 4'hD, 1);
        step("R9 reads", 0, 4'h5, 4'h0, 4'h0, 1);
        // R6: I/O write, hold, other stores leave it
        step("R6 store io", 1, 4'hF, 4'h9, 4'h2, 0);
        step("R6 busy", 0, 4'h1, 4'h4, 4'h2, 0);
        step("R6 loaded", 1, 4'h7, 4'h3, 4'h2, 0);
        step("R6 hold", 0, 4'h7, 4'h0, 4'h2, 0);
        step("R6 hold2", 0, 4'h7, 4'h0, 4'h2, 0);
        // R8: back-to-back stores including same address and I/O
        step("R8 b2b a", 1, 4'h8, 4'h1, 4'h0, 1);
        step("R8 b2b b", 1, 4'h9, 4'h2, 4'h0, 1);
        step("R8 b2b c", 1, 4'h8, 4'h7, 4'h0, 1);
        step("R8 b2b io", 1, 4'hF, 4'hC, 4'h0, 0);
        step("R8 read a", 0, 4'h8, 4'h0, 4'h5, 0);
        step("R8 read b", 0, 4'h9, 4'h0, 4'h5, 0);
        step("R8 read io", 0, 4'hF, 4'h0, 4'h5, 0);
        // Mixed pseudo-random stream
        lfsr = 8'h5B;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step("R2 mix", lfsr[0] & lfsr[3], lfsr[7:4], lfsr[3:0] ^ lfsr[7:4],
                 lfsr[6:3], lfsr[1]);
        end
        // R1: mid-run reset with a store pending
        step("R1 pre", 1, 4'hF, 4'h6, 4'h0, 1);
        @(negedge clk);
        rst = 1'b1; st_req = 1'b0;
        @(posedge clk);
        m_pend = 0; m_oport = '0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 out_port cleared", out_port, 4'h0);
        step("R1 no pending", 0, 4'h3, 4'h0, 4'hB, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule